// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs the external memory cycles of an 8-bit controller whose low address byte and data byte share one set of pins. The core side issues a request with a 16-bit address and a cycle kind, either an instruction fetch or a data read. The sequencer then plays out a fixed pattern of pin activity counted in clock periods. It drives the low address with the latch strobe high, holds the address briefly after the strobe falls, and releases the shared pins. It then pulls the matching active-low enable, samples the returned byte inside that enable window, and signals completion.

The high address byte has its own pins and stays constant for the whole cycle. After the enable rises the sequencer waits out the bus float time before it reports done, so that a following cycle can never drive the shared pins while the memory may still be driving them. A request is taken only while the sequencer is idle. Requests that arrive while it is busy are dropped.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is asserted (rst_ni low) and while idle, ale_o is 0, psen_no and rd_no are 1, ad_oe_o is 0 and busy_o is 0. An asynchronous reset in mid-cycle returns the outputs to this state at once.
- R2: A request with req_i high is accepted at the clock edge where the block is idle. In the accepted cycle ale_o is high for the first 2 clock periods, while ad_oe_o is high and ad_o carries req_addr_i[7:0].
- R3: After ale_o falls, ad_o keeps the low address with ad_oe_o high for exactly 1 more period. ad_oe_o is then low for the rest of the cycle.
- R4: With req_kind_i = 0 (fetch), psen_no is low in periods 3 to 5 of the cycle, counting the first period as 0. That is 1 period after ale_o falls, for 3 periods. rd_no stays high throughout.
- R5: With req_kind_i = 1 (data read), rd_no is low in periods 5 to 10 of the cycle. That is 3 periods after ale_o falls, for 6 periods. psen_no stays high throughout.
- R6: The returned byte on ad_i is sampled at the last edge before the enable rises. For a fetch the data is valid 2 periods after psen_no falls. For a read it is valid 4 periods after rd_no falls. That byte appears on rdata_o.
- R7: ahi_o equals req_addr_i[15:8] of the accepted request in every period of the cycle, and it keeps that value until the next acceptance.
- R8: busy_o is high from the period after acceptance through the last period of the cycle. done_o is high for exactly one period, the last one, which is 2 periods after the enable rises: period 7 for a fetch and period 12 for a read. rdata_o is valid while done_o is high.
- R9: Requests and their address or kind inputs have no effect while busy_o is high. The shared port is not driven again until at least 2 full periods after an enable has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all timing is counted in its periods |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request, taken only when idle |
| req_addr_i | input | 16 | Address of the requested cycle |
| req_kind_i | input | 1 | 0 = program fetch, 1 = data read |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-period completion pulse |
| rdata_o | output | 8 | Captured byte |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Program fetch enable, active low |
| rd_no | output | 1 | Data read strobe, active low |
| ad_o | output | 8 | Low address out on the shared port |
| ad_oe_o | output | 1 | Output enable of the shared port |
| ad_i | input | 8 | Data in from the shared port |
| ahi_o | output | 8 | High address byte |

## Verification
Two events can fall in the same period. The first is the idle period that closes one cycle, which is also the earliest period in which a new request can be accepted. The second is the shared port turning back on, which could collide with the float time left by the enable that just rose. The bench issues requests back to back, alternating fetch and read, with the next request already pending when done_o pulses. A monitor counts the periods from each enable rise to the next rise of ad_oe_o and flags any gap shorter than two. The bus model returns garbage outside its valid window, so a sample taken one edge early or late shows up as a wrong byte on rdata_o.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic {
    CYC_FETCH = 1'b0,
    CYC_READ  = 1'b1
  } cyc_kind_e;

  // last period index of a cycle: latch strobe, delay, enable window, float
  function automatic int cyc_last(int ale_hi, int dly, int width, int flt);
    return ale_hi + dly + width + flt - 1;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CNT_W      = 4,
  parameter int FETCH_LAST = 7,
  parameter int READ_LAST  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [AW-1:0]    req_addr_i,
  input  cyc_kind_e        req_kind_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output cyc_kind_e        kind_o,
  output logic [AW-1:0]    addr_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] F_LAST = CNT_W'(FETCH_LAST);
  localparam logic [CNT_W-1:0] R_LAST = CNT_W'(READ_LAST);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  cyc_kind_e        kind_q;
  logic [AW-1:0]    addr_q;
  logic             at_end;

  assign at_end = cnt_q == ((kind_q == CYC_READ) ? R_LAST : F_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= CYC_FETCH;
      addr_q   <= '0;
    end else if (!active_q) begin
      if (req_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        kind_q   <= req_kind_i;
        addr_q   <= req_addr_i;
      end
    end else if (at_end) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign kind_o   = kind_q;
  assign addr_o   = addr_q;
  assign last_o   = active_q && at_end;

endmodule

// File: rtl/mux_bus_strobe.sv
module mux_bus_strobe
  import mux_bus_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int ALE_HI    = 2,
  parameter int ADR_HOLD  = 1,
  parameter int FETCH_DLY = 1,
  parameter int FETCH_W   = 3,
  parameter int READ_DLY  = 3,
  parameter int READ_W    = 6
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  cyc_kind_e        kind_i,
  output logic             ale_o,
  output logic             ad_oe_o,
  output logic             psen_no,
  output logic             rd_no,
  output logic             cap_o
);

  localparam logic [CNT_W-1:0] ALE_END = CNT_W'(ALE_HI);
  localparam logic [CNT_W-1:0] OE_END  = CNT_W'(ALE_HI + ADR_HOLD);
  localparam logic [CNT_W-1:0] F_BEG   = CNT_W'(ALE_HI + FETCH_DLY);
  localparam logic [CNT_W-1:0] F_END   = CNT_W'(ALE_HI + FETCH_DLY + FETCH_W);
  localparam logic [CNT_W-1:0] R_BEG   = CNT_W'(ALE_HI + READ_DLY);
  localparam logic [CNT_W-1:0] R_END   = CNT_W'(ALE_HI + READ_DLY + READ_W);

  logic f_win, r_win;

  assign ale_o   = active_i && (cnt_i < ALE_END);
  assign ad_oe_o = active_i && (cnt_i < OE_END);

  assign f_win = active_i && (kind_i == CYC_FETCH) && (cnt_i >= F_BEG) && (cnt_i < F_END);
  assign r_win = active_i && (kind_i == CYC_READ)  && (cnt_i >= R_BEG) && (cnt_i < R_END);

  assign psen_no = !f_win;
  assign rd_no   = !r_win;

  // sample on the last edge before the enable rises
  assign cap_o = (f_win && (cnt_i == F_END - CNT_W'(1))) ||
                 (r_win && (cnt_i == R_END - CNT_W'(1)));

endmodule

// File: rtl/mux_bus_capture.sv
module mux_bus_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= ad_i;
  end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ALE_HI    = 2,
  parameter int ADR_HOLD  = 1,
  parameter int FETCH_DLY = 1,
  parameter int FETCH_W   = 3,
  parameter int READ_DLY  = 3,
  parameter int READ_W    = 6,
  parameter int FLOAT_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             req_kind_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic             ale_o,
  output logic             psen_no,
  output logic             rd_no,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  input  logic [DW-1:0]    ad_i,
  output logic [AW-DW-1:0] ahi_o
);

  localparam int FETCH_LAST = cyc_last(ALE_HI, FETCH_DLY, FETCH_W, FLOAT_W);
  localparam int READ_LAST  = cyc_last(ALE_HI, READ_DLY, READ_W, FLOAT_W);
  localparam int MAX_LAST   = max2(FETCH_LAST, READ_LAST);
  localparam int CNT_W      = $clog2(MAX_LAST + 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  cyc_kind_e        kind;
  logic [AW-1:0]    addr;
  logic             last;
  logic             cap;

  mux_bus_ctrl #(
    .AW(AW), .CNT_W(CNT_W), .FETCH_LAST(FETCH_LAST), .READ_LAST(READ_LAST)
  ) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_kind_i(cyc_kind_e'(req_kind_i)), .active_o(active), .cnt_o(cnt),
    .kind_o(kind), .addr_o(addr), .last_o(last)
  );

  mux_bus_strobe #(
    .CNT_W(CNT_W), .ALE_HI(ALE_HI), .ADR_HOLD(ADR_HOLD), .FETCH_DLY(FETCH_DLY),
    .FETCH_W(FETCH_W), .READ_DLY(READ_DLY), .READ_W(READ_W)
  ) strobe_i (
    .active_i(active), .cnt_i(cnt), .kind_i(kind), .ale_o(ale_o),
    .ad_oe_o(ad_oe_o), .psen_no(psen_no), .rd_no(rd_no), .cap_o(cap)
  );

  mux_bus_capture #(.DW(DW)) capture_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .ad_i(ad_i), .rdata_o(rdata_o)
  );

  assign busy_o = active;
  assign done_o = last;
  assign ad_o   = addr[DW-1:0];
  assign ahi_o  = addr[AW-1:DW];

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             ale_o,
  input logic             psen_no,
  input logic             rd_no,
  input logic             ad_oe_o,
  input logic [AW-DW-1:0] ahi_o
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ale_o && psen_no && rd_no && !ad_oe_o));

  // R2
  start_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ale_o && ad_oe_o));

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> ad_oe_o);

  // R4
  one_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!psen_no && !rd_no));

  // R3
  port_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (psen_no && rd_no));

  // R7
  ahi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ahi_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o ##1 (!done_o && !busy_o));

  // R9
  float_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(psen_no) || $rose(rd_no)) |=> !ad_oe_o);

endmodule

bind mux_bus_seq mux_bus_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .ale_o(ale_o), .psen_no(psen_no), .rd_no(rd_no), .ad_oe_o(ad_oe_o),
  .ahi_o(ahi_o)
);

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic        req_kind_i = 1'b0;
  logic        busy_o, done_o, ale_o, psen_no, rd_no, ad_oe_o;
  logic [7:0]  rdata_o, ad_o, ad_i, ahi_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_byte = 8'h00;
  logic [3:0] low_cnt = '0;
  int         since_rise = 99;
  logic       oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mux_bus_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_kind_i(req_kind_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .ale_o(ale_o), .psen_no(psen_no), .rd_no(rd_no), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ahi_o(ahi_o)
  );

  // bus model: valid byte only from the access time until the enable rises
  always @(posedge clk_i) low_cnt <= (!psen_no || !rd_no) ? low_cnt + 4'd1 : 4'd0;
  assign ad_i = ((!psen_no && low_cnt >= 4'd2) || (!rd_no && low_cnt >= 4'd4)) ? mem_byte : ~mem_byte;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R9: float gap monitor
  always @(negedge clk_i) begin
    if (!rst_ni) since_rise = 99;
    else begin
      if (ad_oe_o && !oe_prev) chk(since_rise >= 2, "R9 float gap", since_rise, 2);
      if (!psen_no || !rd_no) since_rise = 0;
      else if (since_rise < 99) since_rise++;
    end
    oe_prev = ad_oe_o;
  end

  task automatic idle_chk(input string tag);
    chk(!busy_o && !ale_o && psen_no && rd_no && !ad_oe_o && !done_o, tag,
        {busy_o, ale_o, psen_no, rd_no, ad_oe_o, done_o}, 6'b001100);
  endtask

  // called at a negedge of an idle period
  task automatic run_cycle(input logic [15:0] a, input bit kind, input bit flood);
    int last;
    last = kind ? 12 : 7;
    req_i = 1'b1; req_addr_i = a; req_kind_i = kind;
    mem_byte = a[7:0] ^ a[15:8] ^ (kind ? 8'h5A : 8'hC3);
    @(negedge clk_i);
    if (flood) begin req_addr_i = ~a; req_kind_i = ~kind; end
    else req_i = 1'b0;
    for (int k = 0; k <= last; k++) begin
      bit en;
      chk(ale_o == (k < 2), "R2 ale", ale_o, k < 2);
      chk(ad_oe_o == (k < 3), "R3 oe", ad_oe_o, k < 3);
      if (k < 3) chk(ad_o == a[7:0], "R2 R3 low addr", ad_o, a[7:0]);
      en = !kind && k >= 3 && k < 6;
      chk(psen_no == !en, "R4 psen", psen_no, !en);
      en = kind && k >= 5 && k < 11;
      chk(rd_no == !en, "R5 rd", rd_no, !en);
      chk(ahi_o == a[15:8], "R7 high addr", ahi_o, a[15:8]);
      chk(busy_o && done_o == (k == last), "R8 busy/done", {busy_o, done_o}, {1'b1, k == last});
      if (k == last) chk(rdata_o == mem_byte, "R6 data", rdata_o, mem_byte);
      if (flood && k == last) req_i = 1'b0;
      @(negedge clk_i);
    end
    idle_chk("R1 idle after cycle");
    chk(ahi_o == a[15:8] && rdata_o == mem_byte, "R9 busy req ignored",
        {ahi_o, rdata_o}, {a[15:8], mem_byte});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    idle_chk("R1 reset");
    req_i = 1'b1;
    @(negedge clk_i);
    idle_chk("R1 req in reset");
    req_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_chk("R1 idle");
    for (int kd = 0; kd < 2; kd++) begin
      for (int i = 0; i < 16; i++) begin
        logic [15:0] a;
        a = (i == 0) ? 16'h0000 : (i == 15) ? 16'hFFFF : 16'(i * 12107 + 5);
        run_cycle(a, (kd[0] ^ i[1]), i[0]);
      end
    end
    // R1: reset in the middle of a read
    req_i = 1'b1; req_addr_i = 16'hA55A; req_kind_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (7) @(negedge clk_i);
    chk(!rd_no, "R5 rd before reset", rd_no, 0);
    rst_ni = 1'b0;
    #1;
    idle_chk("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_chk("R1 after reset release");
    run_cycle(16'h1234, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule